// File: doc/BRIEF.md
# Branch Target Buffer

This block guesses the next fetch address in the same cycle that a branch is fetched. It is a small set-associative store. Each entry holds a valid bit, the upper bits of a branch PC as a tag, and the address that branch last jumped to. The fetch unit presents its current PC and gets back, combinationally, a hit flag, the stored target, and the address to fetch next. On a hit that is the stored target, because a hit alone counts as a taken prediction. On a miss it is the sequential PC + 4.

When a branch resolves later in the pipeline, the update port reports its PC, its outcome and its real target:
- A taken branch is installed, or its existing entry has its target rewritten.
- A not-taken branch that is present has its entry removed.
- A not-taken branch that is absent changes nothing.

Each set keeps a one-bit least-recently-used record. The record is refreshed by lookup hits that fetch actually consumes and by taken updates. It picks the victim when a taken branch has to be allocated into a full set.

The default build has 2 ways and 8 sets, with 32-bit addresses and 4-byte instructions. The set index is PC[4:2]. The tag is PC[31:5].

Top module: `btb_predictor`

## Requirements
- R1: While `rst` is high at a clock edge, every entry becomes invalid. From the next cycle every lookup misses until a taken update installs something.
- R2: A lookup whose PC matches no valid entry gives `lk_hit` = 0 and `lk_next_pc` = `lk_pc` + 4 in the same cycle.
- R3: A lookup whose PC matches a valid entry gives `lk_hit` = 1, and `lk_target` = `lk_next_pc` = that entry's stored target, in the same cycle. The set is chosen by PC[4:2] and the match is on PC[31:5].
- R4: A taken update (`upd_en` = 1, `upd_taken` = 1) for a PC that is absent installs it with `upd_target`. Lookups see the new entry from the cycle after the update edge.
- R5: A not-taken update for a PC that is absent changes no entry and no replacement state.
- R6: A taken update for a PC that is present rewrites that entry's target in place. A PC never occupies two ways of a set.
- R7: A not-taken update for a PC that is present invalidates that entry. Lookups of that PC miss from the next cycle.
- R8: An allocation goes to an invalid way of the set if one exists, choosing way 0 when both are invalid. Only a full set evicts its least-recently-used way.
- R9: A lookup hit with `lk_en` = 1 makes the hit way the most recently used of its set. With `lk_en` = 0 the replacement state is left alone.
- R10: A taken update, whether it allocates or refreshes, makes the written way the most recently used of its set.
- R11: When a lookup and an update occur in the same cycle, the lookup reports the contents from before the update edge. If both refresh the replacement state of the same set, the update's refresh wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Fetch consumes this lookup; qualifies the LRU refresh |
| lk_pc | input | 32 | Fetch PC being looked up |
| lk_hit | output | 1 | PC found in the buffer (predicted taken) |
| lk_target | output | 32 | Stored target on a hit, zero on a miss |
| lk_next_pc | output | 32 | Predicted next fetch address |
| upd_en | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | PC of the resolved branch (word aligned) |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target address |

## Verification
The two functions that can meet in one cycle are a consumed lookup hit and a taken update. Both write the same per-set replacement bit, and the update can also change the entry the lookup is reading.

The bench provokes the first case by:
1. Filling one set.
2. In a single cycle, looking up the way-0 branch and refreshing the way-1 branch.
3. Allocating a third branch into that set.

Only if the update's refresh won does the way-0 branch get evicted, and the bench judges the result by which PCs still hit.

It provokes the second case by installing a PC and looking it up in the same cycle. It expects a miss in that cycle and a hit one cycle later.

// File: rtl/btb_pkg.sv
package btb_pkg;

    parameter int PC_W     = 32;
    parameter int SET_BITS = 3;
    parameter int OFF_BITS = 2;

    // The one-bit replacement record is exact LRU only for two ways.
    localparam int WAYS       = 2;
    localparam int SETS       = 1 << SET_BITS;
    localparam int TAG_W      = PC_W - SET_BITS - OFF_BITS;
    localparam int INSN_BYTES = 1 << OFF_BITS;

    typedef logic [PC_W-1:0]     pc_t;
    typedef logic [SET_BITS-1:0] set_idx_t;
    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic                way_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } btb_key_t;

    typedef struct packed {
        btb_key_t key;
        pc_t      target;
    } btb_entry_t;

    typedef struct packed {
        logic hit;
        way_t way;
    } btb_match_t;

    function automatic set_idx_t set_of(input pc_t pc);
        return pc[OFF_BITS +: SET_BITS];
    endfunction

    function automatic tag_t tag_of(input pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(INSN_BYTES);
    endfunction

endpackage

// File: rtl/btb_way_store.sv
module btb_way_store
    import btb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  set_idx_t   wr_set,
    input  btb_entry_t wr_data,
    input  logic       inv_en,
    input  set_idx_t   inv_set,
    input  set_idx_t   rd_a_set,
    output btb_entry_t rd_a,
    input  set_idx_t   rd_b_set,
    output btb_key_t   rd_b
);

    btb_entry_t mem [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                mem[s].key.valid <= 1'b0;
            end
        end else if (wr_en) begin
            mem[wr_set] <= wr_data;
        end else if (inv_en) begin
            mem[inv_set].key.valid <= 1'b0;
        end
    end

    assign rd_a = mem[rd_a_set];
    assign rd_b = mem[rd_b_set].key;

    // R4
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_set)].key.valid);

    // R7
    inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_en && !wr_en) |=> !mem[$past(inv_set)].key.valid);

    genvar gs;
    generate
        for (gs = 0; gs < SETS; gs++) begin : g_rst_chk
            // R1
            reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> !mem[gs].key.valid);
        end
    endgenerate

endmodule

// File: rtl/btb_match.sv
module btb_match
    import btb_pkg::*;
(
    input  tag_t            tag,
    input  btb_key_t        keys [WAYS],
    output logic [WAYS-1:0] hits,
    output btb_match_t      m
);

    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_cmp
            assign hits[gw] = keys[gw].valid && (keys[gw].tag == tag);
        end
    endgenerate

    always_comb begin
        m.hit = |hits;
        m.way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hits[w]) m.way = way_t'(w);
        end
    end

endmodule

// File: rtl/btb_lru.sv
module btb_lru
    import btb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_touch,
    input  set_idx_t        lk_set,
    input  way_t            lk_way,
    input  logic            up_touch,
    input  set_idx_t        up_set,
    input  way_t            up_way,
    input  set_idx_t        q_set,
    input  logic [WAYS-1:0] q_valid,
    output way_t            victim
);

    // Per set: the way to evict next.
    logic [SETS-1:0] evict_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evict_q <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (up_touch && up_set == set_idx_t'(s)) begin
                    evict_q[s] <= ~up_way;
                end else if (lk_touch && lk_set == set_idx_t'(s)) begin
                    evict_q[s] <= ~lk_way;
                end
            end
        end
    end

    always_comb begin
        if (!q_valid[0])      victim = 1'b0;
        else if (!q_valid[1]) victim = 1'b1;
        else                  victim = evict_q[q_set];
    end

    // R10
    up_touch_chk: assert property (@(posedge clk) disable iff (rst)
        up_touch |=> evict_q[$past(up_set)] == !$past(up_way));

    // R9
    lk_touch_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_touch && !(up_touch && up_set == lk_set))
            |=> evict_q[$past(lk_set)] == !$past(lk_way));

    // R8
    always_comb begin
        if (!rst && q_valid != '1) begin
            victim_free_chk: assert (!q_valid[victim]);
        end
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_en,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    set_idx_t lk_set, up_set;
    tag_t     lk_tag, up_tag;

    assign lk_set = set_of(lk_pc);
    assign lk_tag = tag_of(lk_pc);
    assign up_set = set_of(upd_pc);
    assign up_tag = tag_of(upd_pc);

    btb_entry_t      lk_rd   [WAYS];
    btb_key_t        lk_keys [WAYS];
    btb_key_t        up_keys [WAYS];
    logic [WAYS-1:0] wr_en_w, inv_en_w, up_valid;
    logic [WAYS-1:0] lk_hits, up_hits;
    btb_match_t      lk_m, up_m;
    btb_entry_t      new_entry;
    way_t            victim, dest_way;
    logic            alloc;

    assign alloc     = upd_en && upd_taken;
    assign dest_way  = up_m.hit ? up_m.way : victim;
    assign new_entry = '{key: '{valid: 1'b1, tag: up_tag}, target: upd_target};

    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_way
            assign wr_en_w[gw]  = alloc && (dest_way == way_t'(gw));
            assign inv_en_w[gw] = upd_en && !upd_taken && up_m.hit
                                  && (up_m.way == way_t'(gw));
            assign lk_keys[gw]  = lk_rd[gw].key;
            assign up_valid[gw] = up_keys[gw].valid;

            btb_way_store u_store (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (wr_en_w[gw]),
                .wr_set   (up_set),
                .wr_data  (new_entry),
                .inv_en   (inv_en_w[gw]),
                .inv_set  (up_set),
                .rd_a_set (lk_set),
                .rd_a     (lk_rd[gw]),
                .rd_b_set (up_set),
                .rd_b     (up_keys[gw])
            );
        end
    endgenerate

    btb_match u_lk_match (
        .tag  (lk_tag),
        .keys (lk_keys),
        .hits (lk_hits),
        .m    (lk_m)
    );

    btb_match u_up_match (
        .tag  (up_tag),
        .keys (up_keys),
        .hits (up_hits),
        .m    (up_m)
    );

    btb_lru u_lru (
        .clk      (clk),
        .rst      (rst),
        .lk_touch (lk_en && lk_m.hit),
        .lk_set   (lk_set),
        .lk_way   (lk_m.way),
        .up_touch (alloc),
        .up_set   (up_set),
        .up_way   (dest_way),
        .q_set    (up_set),
        .q_valid  (up_valid),
        .victim   (victim)
    );

    assign lk_hit     = lk_m.hit;
    assign lk_target  = lk_m.hit ? lk_rd[lk_m.way].target : '0;
    assign lk_next_pc = lk_m.hit ? lk_rd[lk_m.way].target : seq_pc(lk_pc);

    // R6
    no_dup_lk_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(lk_hits) <= 1);

    // R6
    no_dup_up_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(up_hits) <= 1);

    // R5
    nt_miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_taken && !up_m.hit) |-> (wr_en_w == '0 && inv_en_w == '0));

    // R4
    always_comb begin
        if (!rst && upd_en) begin
            upd_aligned_chk: assert (upd_pc[OFF_BITS-1:0] == '0);
        end
    end

endmodule

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
    import btb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_en = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_target, lk_next_pc;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    btb_predictor u0 (
        .clk(clk), .rst(rst), .lk_en(lk_en), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_target(lk_target), .lk_next_pc(lk_next_pc), .upd_en(upd_en),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
    );

    task automatic expect_out(input string req, input logic eh, input logic [31:0] en);
        checks++;
        if (lk_hit !== eh || lk_next_pc !== en || lk_target !== (eh ? en : 32'h0)) begin
            errors++;
            $display("FAIL %s pc=%h hit=%b next=%h tgt=%h expected hit=%b next=%h",
                     req, lk_pc, lk_hit, lk_next_pc, lk_target, eh, en);
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc, input logic en,
                        input logic eh, input logic [31:0] en_pc);
        @(negedge clk);
        lk_pc = pc; lk_en = en;
        #2 expect_out(req, eh, en_pc);
        @(negedge clk);
        lk_en = 1'b0;
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        upd_en = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic both(input string req, input logic [31:0] lpc,
                        input logic [31:0] upc, input logic [31:0] utgt,
                        input logic eh, input logic [31:0] en_pc);
        @(negedge clk);
        lk_pc = lpc; lk_en = 1'b1;
        upd_en = 1'b1; upd_pc = upc; upd_taken = 1'b1; upd_target = utgt;
        #2 expect_out(req, eh, en_pc);
        @(negedge clk);
        lk_en = 1'b0; upd_en = 1'b0;
    endtask

    task automatic t_reset;
        look("R1", 32'h100, 1'b0, 1'b0, 32'h104);
        look("R2", 32'h11C, 1'b0, 1'b0, 32'h120);
    endtask

    task automatic t_alloc;
        upd(32'h100, 1'b1, 32'h200);
        look("R4", 32'h100, 1'b0, 1'b1, 32'h200);
        upd(32'h104, 1'b0, 32'h500);
        look("R5", 32'h104, 1'b0, 1'b0, 32'h108);
        look("R3", 32'h500, 1'b0, 1'b0, 32'h504);
    endtask

    task automatic t_ways;
        upd(32'h120, 1'b1, 32'h300);
        look("R8", 32'h100, 1'b0, 1'b1, 32'h200);
        look("R3", 32'h120, 1'b0, 1'b1, 32'h300);
    endtask

    task automatic t_lookup_lru;
        look("R9", 32'h100, 1'b1, 1'b1, 32'h200);
        upd(32'h140, 1'b1, 32'h340);
        look("R9", 32'h100, 1'b0, 1'b1, 32'h200);
        look("R9", 32'h140, 1'b0, 1'b1, 32'h340);
        look("R9", 32'h120, 1'b0, 1'b0, 32'h124);
    endtask

    task automatic t_refresh;
        upd(32'h100, 1'b1, 32'h400);
        look("R6", 32'h100, 1'b0, 1'b1, 32'h400);
        look("R6", 32'h140, 1'b0, 1'b1, 32'h340);
        upd(32'h160, 1'b1, 32'h360);
        look("R10", 32'h160, 1'b0, 1'b1, 32'h360);
        look("R10", 32'h140, 1'b0, 1'b0, 32'h144);
        look("R10", 32'h100, 1'b0, 1'b1, 32'h400);
    endtask

    task automatic t_invalidate;
        upd(32'h160, 1'b0, 32'h0);
        look("R7", 32'h160, 1'b0, 1'b0, 32'h164);
        upd(32'h180, 1'b1, 32'h380);
        look("R8", 32'h100, 1'b0, 1'b1, 32'h400);
        look("R8", 32'h180, 1'b0, 1'b1, 32'h380);
        upd(32'h100, 1'b0, 32'h0);
        look("R7", 32'h100, 1'b0, 1'b0, 32'h104);
    endtask

    task automatic t_same_cycle;
        upd(32'h108, 1'b1, 32'h600);
        upd(32'h128, 1'b1, 32'h628);
        both("R11", 32'h108, 32'h128, 32'h700, 1'b1, 32'h600);
        upd(32'h148, 1'b1, 32'h648);
        look("R11", 32'h108, 1'b0, 1'b0, 32'h10C);
        look("R11", 32'h128, 1'b0, 1'b1, 32'h700);
        look("R11", 32'h148, 1'b0, 1'b1, 32'h648);
        both("R11", 32'h10C, 32'h10C, 32'h70C, 1'b0, 32'h110);
        look("R4", 32'h10C, 1'b0, 1'b1, 32'h70C);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        look("R1", 32'h128, 1'b0, 1'b0, 32'h12C);
        look("R1", 32'h180, 1'b0, 1'b0, 32'h184);
    endtask

    initial begin
        #(20 * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_alloc();
        t_ways();
        t_lookup_lru();
        t_refresh();
        t_invalidate();
        t_same_cycle();
        t_reset_again();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule